// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block divides an incoming clock by 1, 2, 4 or 8 and drives the result onto a single tri-state output. It models the digital part of a small oscillator-plus-divider cell. A chain of three toggle stages counts falling edges of the input clock. A four-way tap mux picks the pass-through clock or one of the stage outputs. Two select pins choose the tap.

An active-low master reset acts without waiting for a clock edge. It clears every stage and blocks the input clock, which stands in for a stopped oscillator. It also releases the output driver, so the output floats. The select and reset pins behave as if they had pull-ups: a Z or X level on any of them is taken as logic 1. An undriven part therefore runs and divides by 8. Once reset is released, the count starts from zero. The divided outputs start low.

Top module: `pow2_clock_divider`

## Requirements
- R1: The stage chain advances only on falling edges of `clk_in`. A rising edge never changes `div_out` in the divided modes.
- R2: With `sel_s1`=1 and `sel_s2`=0, `div_out` follows the first stage. It toggles on every falling edge of `clk_in`, and its first rising edge comes with the first falling edge after reset.
- R3: With `sel_s1`=0 and `sel_s2`=1, `div_out` follows the second stage. It has a period of 4 input cycles and goes high at the 2nd falling edge after reset.
- R4: With `sel_s1`=1 and `sel_s2`=1 (the level of undriven pins), `div_out` follows the third stage. It has a period of 8 input cycles and goes high at the 4th falling edge after reset.
- R5: With `sel_s1`=0 and `sel_s2`=0, `div_out` equals `clk_in` while the block runs: high during the high phase and low during the low phase.
- R6: While `mr_n` is low, `drive_en` is 0 and `div_out` is high impedance. This takes effect at once, with no clock edge needed.
- R7: A low level on `mr_n` clears all stages at once. When `mr_n` is released, every divided output is low, and the count restarts from zero.
- R8: Falling edges of `clk_in` that arrive while `mr_n` is low do not advance the count.
- R9: While `mr_n` is high, `drive_en` is 1 and `div_out` is actively driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; counted on its falling edge |
| sel_s1 | input | 1 | Ratio select, high bit of the pair; pull-up level is 1 |
| sel_s2 | input | 1 | Ratio select, low bit of the pair; pull-up level is 1 |
| mr_n | input | 1 | Active-low asynchronous master reset; pull-up level is 1 |
| div_out | output | 1 | Divided clock through a tri-state driver |
| drive_en | output | 1 | High while the output driver is enabled |

## Verification
The checker follows the stages at every input clock edge. It checks four things: the count rises by exactly one per falling edge while running, it is held at zero during reset, the driver is off during reset and on otherwise, and the tap follows the right stage in the divide-by-8 and pass-through modes. Some behaviour only the bench scenarios can show. These are the exact edge on which each ratio first goes high, the continuous counting across mid-run ratio changes, the immediate float and clear when reset arrives mid-phase, and the restart from zero after a reset that cuts a run short.

// File: rtl/pow2div_pkg.sv
`timescale 1ns/1ps
package pow2div_pkg;

    // Number of toggle stages in the chain.
    localparam int DIV_STAGES = 3;

    // Tap selection; the enum value is the tap index into the mux.
    typedef enum logic [1:0] {
        RATIO_PASS = 2'd0,
        RATIO_BY2  = 2'd1,
        RATIO_BY4  = 2'd2,
        RATIO_BY8  = 2'd3
    } ratio_e;

    // Pin levels after pull-up modelling.
    typedef struct packed {
        logic s1;
        logic s2;
        logic run;
    } pin_levels_t;

    // A pin with a pull-up reads 1 unless it is actively driven low.
    function automatic logic pulled_up(input logic v);
        return (v === 1'b0) ? 1'b0 : 1'b1;
    endfunction

    // Select pair to ratio: 00 pass, 10 by 2, 01 by 4, 11 by 8.
    function automatic ratio_e decode_ratio(input logic s1, input logic s2);
        ratio_e r;
        case ({s1, s2})
            2'b00:   r = RATIO_PASS;
            2'b10:   r = RATIO_BY2;
            2'b01:   r = RATIO_BY4;
            default: r = RATIO_BY8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pow2div_pin_cond.sv
`timescale 1ns/1ps
module pow2div_pin_cond
    import pow2div_pkg::*;
(
    input  logic        sel_s1,
    input  logic        sel_s2,
    input  logic        mr_n,
    output pin_levels_t levels
);
    // Undriven or unknown pins resolve to their pull-up level.
    always_comb begin
        levels.s1  = pulled_up(sel_s1);
        levels.s2  = pulled_up(sel_s2);
        levels.run = pulled_up(mr_n);
    end
endmodule

// File: rtl/pow2div_toggle_stage.sv
`timescale 1ns/1ps
module pow2div_toggle_stage (
    input  logic clk_fall,
    input  logic rst,
    output logic q
);
    // One binary stage: toggles on the falling edge of its clock and
    // clears at once while rst is high.
    always_ff @(negedge clk_fall or posedge rst) begin
        if (rst) q <= 1'b0;
        else     q <= ~q;
    end
endmodule

// File: rtl/pow2div_tap_mux.sv
`timescale 1ns/1ps
module pow2div_tap_mux
    import pow2div_pkg::*;
#(
    parameter int STAGES = DIV_STAGES
)(
    input  logic [STAGES:0] taps,
    input  ratio_e          ratio,
    output logic            level
);
    localparam int IDX_W = (STAGES < 1) ? 1 : $clog2(STAGES + 1);

    logic [IDX_W-1:0] idx;

    // Clamp the requested tap to the last stage when the chain is short.
    always_comb begin
        if (int'(ratio) > STAGES) idx = IDX_W'(STAGES);
        else                      idx = IDX_W'(ratio);
        level = taps[idx];
    end
endmodule

// File: rtl/pow2_clock_divider.sv
`timescale 1ns/1ps
module pow2_clock_divider
    import pow2div_pkg::*;
#(
    parameter int STAGES = DIV_STAGES
)(
    input  logic clk_in,
    input  logic sel_s1,
    input  logic sel_s2,
    input  logic mr_n,
    output logic div_out,
    output logic drive_en
);
    pin_levels_t    levels;
    ratio_e         ratio;
    logic           rst;
    logic [STAGES:0] taps;
    logic           tap_level;

    pow2div_pin_cond u_pins (
        .sel_s1 (sel_s1),
        .sel_s2 (sel_s2),
        .mr_n   (mr_n),
        .levels (levels)
    );

    assign rst   = ~levels.run;
    assign ratio = decode_ratio(levels.s1, levels.s2);

    // Tap 0 is the input clock gated by the run level (stopped source).
    assign taps[0] = clk_in & levels.run;

    // Each stage is clocked by the falling edge of the one before it.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        pow2div_toggle_stage u_stage (
            .clk_fall (taps[i]),
            .rst      (rst),
            .q        (taps[i+1])
        );
    end

    pow2div_tap_mux #(.STAGES(STAGES)) u_mux (
        .taps  (taps),
        .ratio (ratio),
        .level (tap_level)
    );

    assign drive_en = levels.run;
    assign div_out  = drive_en ? tap_level : 1'bz;

endmodule

// File: rtl/pow2div_checker.sv
`timescale 1ns/1ps
module pow2div_checker #(
    parameter int STAGES = 3
)(
    input logic              clk_in,
    input logic              mr_n,
    input logic              sel_s1,
    input logic              sel_s2,
    input logic              drive_en,
    input logic              tap_level,
    input logic [STAGES-1:0] cnt
);
    localparam logic [STAGES-1:0] ONE = 1;

    // Set once a rising edge has been seen outside reset.
    logic armed;
    always_ff @(posedge clk_in or negedge mr_n) begin
        if (!mr_n) armed <= 1'b0;
        else       armed <= 1'b1;
    end

    // R6: driver released whenever reset is low.
    a_r6_float_in_reset: assert property (@(negedge clk_in)
        !mr_n |-> !drive_en);

    // R8: no counting while reset is low.
    a_r8_hold_in_reset: assert property (@(posedge clk_in)
        !mr_n |-> (cnt == '0));

    // R1: exactly one step per input period while running.
    a_r1_count_step: assert property (@(posedge clk_in) disable iff (!mr_n)
        armed |-> (cnt == ($past(cnt) + ONE)));

    // R9: driver enabled while running.
    a_r9_drive_when_run: assert property (@(posedge clk_in) disable iff (!mr_n)
        drive_en);

    // R4: divide-by-8 tap follows the last stage.
    a_r4_tap_last_stage: assert property (@(posedge clk_in) disable iff (!mr_n)
        (sel_s1 && sel_s2) |-> (tap_level == cnt[STAGES-1]));

    // R5: pass-through is high just before each falling edge.
    a_r5_pass_high: assert property (@(negedge clk_in) disable iff (!mr_n)
        (!sel_s1 && !sel_s2) |-> tap_level);

endmodule

bind pow2_clock_divider pow2div_checker #(.STAGES(STAGES)) u_chk (
    .clk_in    (clk_in),
    .mr_n      (mr_n),
    .sel_s1    (sel_s1),
    .sel_s2    (sel_s2),
    .drive_en  (drive_en),
    .tap_level (tap_level),
    .cnt       (taps[STAGES:1])
);

// File: tb/pow2_clock_divider_tb.sv
`timescale 1ns/1ps
module pow2_clock_divider_tb;

    logic clk = 1'b0;
    logic sel_s1 = 1'b1;
    logic sel_s2 = 1'b1;
    logic mr_n = 1'b0;
    wire  div_out_w;
    logic drive_en;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit done   = 0;

    typedef struct {
        logic  level;
        string req;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    pow2_clock_divider u_dut (
        .clk_in   (clk),
        .sel_s1   (sel_s1),
        .sel_s2   (sel_s2),
        .mr_n     (mr_n),
        .div_out  (div_out_w),
        .drive_en (drive_en)
    );

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
        end
    endtask

    // Monitor: compares the output in each low phase with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.req, div_out_w, it.level);
            end
        end
    end

    // Driver: call while clk is high, after a rising edge. Pushes one
    // expectation per coming falling edge.
    task automatic run_mode(input logic s1, input logic s2, input int tap,
                            input int n, input string req);
        sel_s1 = s1;
        sel_s2 = s2;
        #1;
        for (int k = 0; k < n; k++) begin
            sb_item_t it;
            if (tap == 0) begin
                check("R5 pass high phase", div_out_w, 1'b1);
                it.level = 1'b0;
            end else begin
                // R1: state from the last falling edge, unchanged by the rising edge
                check("R1 no change on rising edge", div_out_w,
                      logic'((edges >> (tap - 1)) & 1));
                it.level = logic'(((edges + 1) >> (tap - 1)) & 1);
            end
            it.req = req;
            sb_q.push_back(it);
            edges++;
            @(posedge clk);
            #2;
        end
    endtask

    // Reset applied mid high phase; released in a later high phase.
    task automatic do_reset();
        mr_n = 1'b0;
        #1;
        check("R6 driver off at once", drive_en, 1'b0);
        repeat (3) @(negedge clk);
        #5;
        check("R6 driver off in low phase", drive_en, 1'b0);
        @(posedge clk);
        #2;
        mr_n = 1'b1;
        #1;
        check("R9 driver on after release", drive_en, 1'b1);
        check("R7 output cleared at release", div_out_w, 1'b0);
        edges = 0;
    endtask

    initial begin
        @(posedge clk);
        #2;
        check("R6 reset state driver off", drive_en, 1'b0);
        do_reset();
        run_mode(1'b1, 1'b1, 3, 20, "R4 divide by 8");
        run_mode(1'b1, 1'b0, 1, 9,  "R2 divide by 2");
        run_mode(1'b0, 1'b1, 2, 10, "R3 divide by 4");
        run_mode(1'b0, 1'b0, 0, 6,  "R5 pass through");
        run_mode(1'b1, 1'b0, 1, 3,  "R2 divide by 2 resumed");
        sel_s1 = 1'b0; sel_s2 = 1'b1;
        do_reset();
        run_mode(1'b0, 1'b1, 2, 6,  "R7 R8 restart divide by 4");
        run_mode(1'b1, 1'b1, 3, 5,  "R4 divide by 8 after restart");
        sel_s1 = 1'b1; sel_s2 = 1'b0;
        do_reset();
        run_mode(1'b1, 1'b0, 1, 4,  "R7 R8 restart divide by 2");
        repeat (2) @(negedge clk);
        #6;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule